// File: doc/BRIEF.md
# Initiator Bus Phase Dispatcher

This block runs the information-transfer loop of an initiator on a parallel peripheral bus once a connection exists. A connection starts in one of two ways: an outgoing selection completes, or a target reselects the initiator. The block then records which target it is talking to and which message it will send first. After that it waits for the target's REQ. When REQ arrives it samples the three phase lines and starts exactly one handler: data, command, message-out, status or message-in. Each handler is started with a one-cycle pulse and reports back through a shared done input.

A handler that ends the connection sends the block into a bus-free wait. On entry to that wait, the block acknowledges the last byte, clears all per-target state and turns off the unexpected-bus-free interrupt enable. It then waits until the bus goes free, or raises a bad-phase interrupt if the target asserts REQ again. A phase code that matches no handler also raises the bad-phase interrupt, and the block goes back to waiting for REQ. Moving bytes inside the handlers is left to the handlers.

Top module: `xfer_phase_sequencer`

## Requirements
- R1: After reset, no handler start, bad-phase, acknowledge or clear pulse is active. The pending message is NOOP (8'h08), the flags and transfer settings are zero, the last phase is the bus-free code 4'b1000 and the bus-free interrupt enable is low.
- R2: A selection-complete pulse in idle sets the pending message to IDENTIFY (8'h80), sets the identify-seen flag (flags bit 0), takes the target ID from the queued-target input and sets the bus-free interrupt enable. If reselection arrives in the same cycle, selection wins.
- R3: A reselection pulse in idle sets the pending message to NOOP (8'h08), takes the target ID from the reselecting ID input, leaves the identify-seen flag clear and sets the bus-free interrupt enable.
- R4: The phase lines are sampled only while a connection waits for a phase and REQ is high. REQ in idle, or while a handler is running, starts nothing.
- R5: The phase bits are ordered {MSG, C/D, I/O}. Codes 000 and 001 start the data handler (start bit 0), 010 the command handler (bit 1), 110 message-out (bit 2), 011 status (bit 3) and 111 message-in (bit 4). The start is a one-hot pulse of one cycle, visible in the cycle after REQ is sampled.
- R6: Codes 100 and 101 raise a one-cycle bad-phase pulse, start no handler, and leave the block waiting for REQ, so that the next valid phase is dispatched.
- R7: Every sample loads the last-phase output with {1'b0, phase}, bad codes included. A dispatch to the data handler sets the data-seen flag (flags bit 1).
- R8: A done without the end-connection qualifier returns the block to waiting for REQ. A done with it raises the acknowledge and clear pulses together for one cycle and drops the bus-free interrupt enable.
- R9: Clearing target state sets the transfer settings to zero (narrow, asynchronous), the last phase to 4'b1000 and both flags to zero.
- R10: In the bus-free wait, bus-free returns the block to idle. REQ without bus-free raises one bad-phase pulse and also returns to idle. Bus-free wins if both are present.
- R11: A transfer-settings write loads the settings only while a connection is open; in idle it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_done_i | input | 1 | Outgoing selection completed (pulse) |
| sel_tid_i | input | ID_W | Target ID of the queued selection |
| resel_i | input | 1 | Reselection by a target detected (pulse) |
| resel_id_i | input | ID_W | Target ID taken from the selection ID bits |
| req_i | input | 1 | Target REQ |
| phase_i | input | 3 | Phase lines {MSG, C/D, I/O} |
| bus_free_i | input | 1 | Bus-free detected |
| hnd_done_i | input | 1 | Active handler finished |
| hnd_end_i | input | 1 | Qualifies done: connection is ending |
| xfer_cfg_we_i | input | 1 | Write strobe for negotiated transfer settings |
| xfer_cfg_i | input | CFG_W | Negotiated transfer settings |
| hnd_start_o | output | 5 | One-hot handler start pulses |
| bad_phase_irq_o | output | 1 | Bad-phase interrupt pulse |
| ack_o | output | 1 | Acknowledge-last-byte pulse |
| clr_state_o | output | 1 | Per-target state clear pulse |
| msg_out_o | output | 8 | Pending first outgoing message |
| target_id_o | output | ID_W | Connected target ID |
| flags_o | output | 2 | {data-seen, identify-seen} |
| last_phase_o | output | 4 | Last sampled phase, 4'b1000 for bus-free |
| xfer_cfg_o | output | CFG_W | Current transfer settings |
| busfree_irq_en_o | output | 1 | Unexpected bus-free interrupt enable |

## Verification
Every result is registered, so each result is due in the cycle after the clock edge that samples its cause. This holds for a handler start, a bad-phase pulse, the acknowledge and clear pulses, and the context loaded on selection or reselection. The bench changes inputs at the falling edge and reads outputs at the next falling edge, which is exactly one rising edge later. It then checks one further cycle to show that each pulse has already ended. Checks that a stimulus was ignored (REQ in idle, REQ during a handler, a settings write in idle) read the outputs in the cycle where a response would have appeared.

// File: rtl/xps_pkg.sv
package xps_pkg;
  localparam int N_HND = 5;
  localparam int H_DATA = 0;
  localparam int H_CMD  = 1;
  localparam int H_MOUT = 2;
  localparam int H_STAT = 3;
  localparam int H_MIN  = 4;

  typedef enum logic [2:0] {
    PH_DOUT = 3'b000,
    PH_DIN  = 3'b001,
    PH_CMD  = 3'b010,
    PH_STAT = 3'b011,
    PH_RSV0 = 3'b100,
    PH_RSV1 = 3'b101,
    PH_MOUT = 3'b110,
    PH_MIN  = 3'b111
  } bus_phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_REQ,
    ST_BUSY,
    ST_BF_WAIT
  } ctl_state_e;

  localparam logic [7:0] MSG_IDENT    = 8'h80;
  localparam logic [7:0] MSG_NOP      = 8'h08;
  localparam logic [3:0] LAST_BUSFREE = 4'b1000;
endpackage

// File: rtl/xps_phase_decode.sv
module xps_phase_decode
  import xps_pkg::*;
(
  input  logic [2:0]       phase_i,
  output logic [N_HND-1:0] onehot_o,
  output logic             bad_o
);
  always_comb begin
    onehot_o = '0;
    bad_o    = 1'b0;
    case (bus_phase_e'(phase_i))
      PH_DOUT, PH_DIN: onehot_o[H_DATA] = 1'b1;
      PH_CMD:          onehot_o[H_CMD]  = 1'b1;
      PH_MOUT:         onehot_o[H_MOUT] = 1'b1;
      PH_STAT:         onehot_o[H_STAT] = 1'b1;
      PH_MIN:          onehot_o[H_MIN]  = 1'b1;
      default:         bad_o            = 1'b1;
    endcase
  end
endmodule

// File: rtl/xps_ctrl_fsm.sv
module xps_ctrl_fsm
  import xps_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_done_i,
  input  logic             resel_i,
  input  logic             req_i,
  input  logic             bus_free_i,
  input  logic             hnd_done_i,
  input  logic             hnd_end_i,
  input  logic [N_HND-1:0] dec_onehot_i,
  input  logic             dec_bad_i,
  output logic             ev_sel_o,
  output logic             ev_resel_o,
  output logic             ev_sample_o,
  output logic             ev_clear_o,
  output logic             connected_o,
  output logic [N_HND-1:0] start_o,
  output logic             bad_o,
  output logic             ack_o,
  output logic             clr_o
);
  ctl_state_e       state_q, state_d;
  logic [N_HND-1:0] start_q, start_d;
  logic             bad_q, bad_d;
  logic             ack_q, ack_d;
  logic             clr_q, clr_d;

  always_comb begin
    state_d     = state_q;
    start_d     = '0;
    bad_d       = 1'b0;
    ack_d       = 1'b0;
    clr_d       = 1'b0;
    ev_sel_o    = 1'b0;
    ev_resel_o  = 1'b0;
    ev_sample_o = 1'b0;
    ev_clear_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sel_done_i) begin
          ev_sel_o = 1'b1;
          state_d  = ST_WAIT_REQ;
        end else if (resel_i) begin
          ev_resel_o = 1'b1;
          state_d    = ST_WAIT_REQ;
        end
      end
      ST_WAIT_REQ: begin
        if (req_i) begin
          ev_sample_o = 1'b1;
          if (dec_bad_i) begin
            bad_d = 1'b1;
          end else begin
            start_d = dec_onehot_i;
            state_d = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (hnd_done_i) begin
          if (hnd_end_i) begin
            ev_clear_o = 1'b1;
            ack_d      = 1'b1;
            clr_d      = 1'b1;
            state_d    = ST_BF_WAIT;
          end else begin
            state_d = ST_WAIT_REQ;
          end
        end
      end
      ST_BF_WAIT: begin
        if (bus_free_i) begin
          state_d = ST_IDLE;
        end else if (req_i) begin
          bad_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      start_q <= '0;
      bad_q   <= 1'b0;
      ack_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      bad_q   <= bad_d;
      ack_q   <= ack_d;
      clr_q   <= clr_d;
    end
  end

  assign connected_o = (state_q == ST_WAIT_REQ) || (state_q == ST_BUSY);
  assign start_o     = start_q;
  assign bad_o       = bad_q;
  assign ack_o       = ack_q;
  assign clr_o       = clr_q;
endmodule

// File: rtl/xps_conn_ctx.sv
module xps_conn_ctx
  import xps_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_sel_i,
  input  logic             ev_resel_i,
  input  logic             ev_sample_i,
  input  logic             ev_data_i,
  input  logic             ev_clear_i,
  input  logic             cfg_en_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [2:0]       phase_i,
  input  logic [ID_W-1:0]  sel_tid_i,
  input  logic [ID_W-1:0]  resel_id_i,
  output logic [7:0]       msg_o,
  output logic [ID_W-1:0]  tid_o,
  output logic [1:0]       flags_o,
  output logic [3:0]       last_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             bf_en_o
);
  localparam int FLG_IDENT = 0;
  localparam int FLG_DATA  = 1;

  logic [7:0]       msg_q, msg_d;
  logic [ID_W-1:0]  tid_q, tid_d;
  logic [1:0]       flg_q, flg_d;
  logic [3:0]       last_q, last_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             bfen_q, bfen_d;

  always_comb begin
    msg_d  = msg_q;
    tid_d  = tid_q;
    flg_d  = flg_q;
    last_d = last_q;
    cfg_d  = cfg_q;
    bfen_d = bfen_q;
    if (ev_clear_i) begin
      cfg_d  = '0;
      flg_d  = '0;
      last_d = LAST_BUSFREE;
      bfen_d = 1'b0;
    end else begin
      if (ev_sel_i) begin
        msg_d            = MSG_IDENT;
        tid_d            = sel_tid_i;
        flg_d[FLG_IDENT] = 1'b1;
        bfen_d           = 1'b1;
      end else if (ev_resel_i) begin
        msg_d            = MSG_NOP;
        tid_d            = resel_id_i;
        flg_d[FLG_IDENT] = 1'b0;
        bfen_d           = 1'b1;
      end
      if (ev_sample_i) begin
        last_d = {1'b0, phase_i};
      end
      if (ev_data_i) begin
        flg_d[FLG_DATA] = 1'b1;
      end
      if (cfg_en_i) begin
        cfg_d = cfg_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_q  <= MSG_NOP;
      tid_q  <= '0;
      flg_q  <= '0;
      last_q <= LAST_BUSFREE;
      cfg_q  <= '0;
      bfen_q <= 1'b0;
    end else begin
      msg_q  <= msg_d;
      tid_q  <= tid_d;
      flg_q  <= flg_d;
      last_q <= last_d;
      cfg_q  <= cfg_d;
      bfen_q <= bfen_d;
    end
  end

  assign msg_o   = msg_q;
  assign tid_o   = tid_q;
  assign flags_o = flg_q;
  assign last_o  = last_q;
  assign cfg_o   = cfg_q;
  assign bf_en_o = bfen_q;
endmodule

// File: rtl/xfer_phase_sequencer.sv
module xfer_phase_sequencer
  import xps_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_done_i,
  input  logic [ID_W-1:0]  sel_tid_i,
  input  logic             resel_i,
  input  logic [ID_W-1:0]  resel_id_i,
  input  logic             req_i,
  input  logic [2:0]       phase_i,
  input  logic             bus_free_i,
  input  logic             hnd_done_i,
  input  logic             hnd_end_i,
  input  logic             xfer_cfg_we_i,
  input  logic [CFG_W-1:0] xfer_cfg_i,
  output logic [4:0]       hnd_start_o,
  output logic             bad_phase_irq_o,
  output logic             ack_o,
  output logic             clr_state_o,
  output logic [7:0]       msg_out_o,
  output logic [ID_W-1:0]  target_id_o,
  output logic [1:0]       flags_o,
  output logic [3:0]       last_phase_o,
  output logic [CFG_W-1:0] xfer_cfg_o,
  output logic             busfree_irq_en_o
);
  logic [N_HND-1:0] dec_onehot;
  logic             dec_bad;
  logic             ev_sel, ev_resel, ev_sample, ev_clear, connected;
  logic [N_HND-1:0] start_w;

  xps_phase_decode u_dec (
    .phase_i  (phase_i),
    .onehot_o (dec_onehot),
    .bad_o    (dec_bad)
  );

  xps_ctrl_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_done_i   (sel_done_i),
    .resel_i      (resel_i),
    .req_i        (req_i),
    .bus_free_i   (bus_free_i),
    .hnd_done_i   (hnd_done_i),
    .hnd_end_i    (hnd_end_i),
    .dec_onehot_i (dec_onehot),
    .dec_bad_i    (dec_bad),
    .ev_sel_o     (ev_sel),
    .ev_resel_o   (ev_resel),
    .ev_sample_o  (ev_sample),
    .ev_clear_o   (ev_clear),
    .connected_o  (connected),
    .start_o      (start_w),
    .bad_o        (bad_phase_irq_o),
    .ack_o        (ack_o),
    .clr_o        (clr_state_o)
  );

  xps_conn_ctx #(.ID_W(ID_W), .CFG_W(CFG_W)) u_ctx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_sel_i    (ev_sel),
    .ev_resel_i  (ev_resel),
    .ev_sample_i (ev_sample),
    .ev_data_i   (ev_sample & dec_onehot[H_DATA]),
    .ev_clear_i  (ev_clear),
    .cfg_en_i    (xfer_cfg_we_i & connected),
    .cfg_i       (xfer_cfg_i),
    .phase_i     (phase_i),
    .sel_tid_i   (sel_tid_i),
    .resel_id_i  (resel_id_i),
    .msg_o       (msg_out_o),
    .tid_o       (target_id_o),
    .flags_o     (flags_o),
    .last_o      (last_phase_o),
    .cfg_o       (xfer_cfg_o),
    .bf_en_o     (busfree_irq_en_o)
  );

  assign hnd_start_o = start_w;
endmodule

// File: rtl/xps_checker.sv
module xps_checker #(
  parameter int ID_W  = 4,
  parameter int CFG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [4:0]       hnd_start_o,
  input logic             bad_phase_irq_o,
  input logic             ack_o,
  input logic             clr_state_o,
  input logic [7:0]       msg_out_o,
  input logic [1:0]       flags_o,
  input logic [3:0]       last_phase_o,
  input logic [CFG_W-1:0] xfer_cfg_o,
  input logic             busfree_irq_en_o
);
  AST_START_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hnd_start_o)); // R5
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hnd_start_o) |=> (hnd_start_o == '0)); // R5
  AST_START_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hnd_start_o) |-> $past(req_i)); // R4
  AST_BAD_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_phase_irq_o |-> (hnd_start_o == '0)); // R6
  AST_CLEAR_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_state_o |-> (last_phase_o == 4'b1000 && flags_o == 2'b00 && xfer_cfg_o == '0)); // R9
  AST_ACK_IRQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !busfree_irq_en_o); // R8
  AST_IDENT_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[0]) |-> (msg_out_o == 8'h80)); // R2
endmodule

bind xfer_phase_sequencer xps_checker #(.ID_W(ID_W), .CFG_W(CFG_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_i            (req_i),
  .hnd_start_o      (hnd_start_o),
  .bad_phase_irq_o  (bad_phase_irq_o),
  .ack_o            (ack_o),
  .clr_state_o      (clr_state_o),
  .msg_out_o        (msg_out_o),
  .flags_o          (flags_o),
  .last_phase_o     (last_phase_o),
  .xfer_cfg_o       (xfer_cfg_o),
  .busfree_irq_en_o (busfree_irq_en_o)
);

// File: tb/sim_xfer_phase_sequencer.sv
`timescale 1ns/1ps
module sim_xfer_phase_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_done = 1'b0, resel = 1'b0, req = 1'b0, bus_free = 1'b0;
  logic       done = 1'b0, end_c = 1'b0, cfg_we = 1'b0;
  logic [3:0] sel_tid = '0, resel_id = '0;
  logic [2:0] phase = '0;
  logic [7:0] cfg_in = '0;
  logic [4:0] start;
  logic       bad, ack, clr, bf_en;
  logic [7:0] msg, cfg_out;
  logic [3:0] tid, last;
  logic [1:0] flags;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  xfer_phase_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_done_i(sel_done), .sel_tid_i(sel_tid),
    .resel_i(resel), .resel_id_i(resel_id), .req_i(req), .phase_i(phase),
    .bus_free_i(bus_free), .hnd_done_i(done), .hnd_end_i(end_c),
    .xfer_cfg_we_i(cfg_we), .xfer_cfg_i(cfg_in), .hnd_start_o(start),
    .bad_phase_irq_o(bad), .ack_o(ack), .clr_state_o(clr), .msg_out_o(msg),
    .target_id_o(tid), .flags_o(flags), .last_phase_o(last),
    .xfer_cfg_o(cfg_out), .busfree_irq_en_o(bf_en));

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "start", 32'(start), 0);
    check("R1", "bad/ack/clr", 32'({bad, ack, clr}), 0);
    check("R1", "msg", 32'(msg), 32'h08);
    check("R1", "flags", 32'(flags), 0);
    check("R1", "cfg", 32'(cfg_out), 0);
    check("R1", "last", 32'(last), 32'h8);
    check("R1", "irq en", 32'(bf_en), 0);
  endtask

  task automatic t_idle_ignores;
    req = 1'b1; phase = 3'b000; cfg_we = 1'b1; cfg_in = 8'h3C;
    tick;
    check("R4", "idle req start", 32'(start), 0);
    check("R11", "idle cfg write", 32'(cfg_out), 0);
    req = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic t_select(input logic [3:0] id);
    sel_done = 1'b1; resel = 1'b1; sel_tid = id; resel_id = ~id;
    tick;
    sel_done = 1'b0; resel = 1'b0;
    check("R2", "msg", 32'(msg), 32'h80);
    check("R2", "tid", 32'(tid), 32'(id));
    check("R2", "ident flag", 32'(flags[0]), 1);
    check("R2", "irq en", 32'(bf_en), 1);
  endtask

  task automatic t_reselect(input logic [3:0] id);
    resel = 1'b1; resel_id = id;
    tick;
    resel = 1'b0;
    check("R3", "msg", 32'(msg), 32'h08);
    check("R3", "tid", 32'(tid), 32'(id));
    check("R3", "ident flag", 32'(flags[0]), 0);
    check("R3", "irq en", 32'(bf_en), 1);
  endtask

  task automatic t_phase(input logic [2:0] ph, input logic [4:0] exp);
    req = 1'b1; phase = ph;
    tick;
    check("R5", "start", 32'(start), 32'(exp));
    check("R7", "last", 32'(last), 32'({1'b0, ph}));
    if (exp[0]) check("R7", "data flag", 32'(flags[1]), 1);
    tick;
    check("R5", "pulse end", 32'(start), 0);
    check("R4", "busy ignores req", 32'(start), 0);
    req = 1'b0; done = 1'b1;
    tick;
    done = 1'b0;
  endtask

  task automatic t_bad(input logic [2:0] ph);
    req = 1'b1; phase = ph;
    tick;
    req = 1'b0;
    check("R6", "bad pulse", 32'(bad), 1);
    check("R6", "no start", 32'(start), 0);
    check("R7", "last bad", 32'(last), 32'({1'b0, ph}));
    tick;
    check("R6", "bad one cycle", 32'(bad), 0);
    req = 1'b1; phase = 3'b010;
    tick;
    req = 1'b0;
    check("R6", "still waiting", 32'(start), 32'h02);
    tick;
    done = 1'b1;
    tick;
    done = 1'b0;
  endtask

  task automatic t_cfg;
    cfg_we = 1'b1; cfg_in = 8'hA5;
    tick;
    cfg_we = 1'b0;
    check("R11", "cfg load", 32'(cfg_out), 32'hA5);
  endtask

  task automatic t_end(input logic via_req);
    req = 1'b1; phase = 3'b111;
    tick;
    req = 1'b0;
    check("R5", "msg-in start", 32'(start), 32'h10);
    done = 1'b1; end_c = 1'b1;
    tick;
    done = 1'b0; end_c = 1'b0;
    check("R8", "ack", 32'(ack), 1);
    check("R8", "clr", 32'(clr), 1);
    check("R8", "irq en off", 32'(bf_en), 0);
    check("R9", "cfg", 32'(cfg_out), 0);
    check("R9", "flags", 32'(flags), 0);
    check("R9", "last", 32'(last), 32'h8);
    tick;
    check("R8", "ack one cycle", 32'({ack, clr}), 0);
    if (via_req) begin
      req = 1'b1;
      tick;
      req = 1'b0;
      check("R10", "req in bf wait", 32'(bad), 1);
    end else begin
      bus_free = 1'b1; req = 1'b1;
      tick;
      bus_free = 1'b0; req = 1'b0;
      check("R10", "bus free wins", 32'(bad), 0);
    end
    req = 1'b1; phase = 3'b000;
    tick;
    req = 1'b0;
    check("R10", "back in idle", 32'({start, bad}), 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick;
    t_reset;
    t_idle_ignores;
    t_select(4'd5);
    t_phase(3'b000, 5'h01);
    t_phase(3'b001, 5'h01);
    t_phase(3'b010, 5'h02);
    t_phase(3'b110, 5'h04);
    t_phase(3'b011, 5'h08);
    t_phase(3'b111, 5'h10);
    t_bad(3'b100);
    t_bad(3'b101);
    t_cfg;
    t_end(1'b0);
    t_reselect(4'd3);
    t_phase(3'b110, 5'h04);
    t_end(1'b1);
    finish_run;
  end
endmodule